// File: doc/BRIEF.md
# Character LCD Power-Up Command Sequencer

This block brings a parallel character LCD controller out of power-up by itself. It runs on one fast system clock. A free-running prescaler produces a single-cycle step strobe, and the control state machine and the wait counter both advance only on that strobe, so the slow bus timing needs no second clock. When a start pulse arrives, the sequencer waits out the controller's power-up settling time. It then performs eight command writes in 8-bit bus mode. Each write is followed by a timed pause whose length depends on the command. After the last pause it raises a done flag and leaves the bus quiet.

One write takes three strobe periods: the byte is placed on the bus, the enable line is held high, and the enable line is held low with the byte unchanged. After that comes the pause, measured by a separate counter that is held at zero outside pauses. Long pauses run that counter up to all ones. The power-up settling time is several such long pauses in a row. Register select and read/write are held low throughout, because every access is a command write.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is low, and afterwards until start_i is seen high, en_o, rs_o, rw_o and done_o stay low and no enable pulse appears.
- R2: The first enable rising edge after start_i arrives between (PWR_LOOPS*2^DELAY_W+1)*DIV+1 and (PWR_LOOPS*2^DELAY_W+2)*DIV clock cycles after the start pulse, where DIV = 2^PRESCALE_W.
- R3: Exactly eight command bytes are written. Sampled when en_o falls, they are, in order: 0x30, 0x30, 0x30, 0x38, 0x08, 0x01, 0x06, 0x0C.
- R4: rs_o and rw_o are low on every enable pulse.
- R5: Each enable pulse stays high for exactly DIV clock cycles.
- R6: data_o holds its value for the whole time en_o is high and for DIV cycles after en_o falls.
- R7: The time from an enable falling edge to the next rising edge is (T+3)*DIV cycles. T is the pause count of the command just written: 2^DELAY_W-1 after the first 0x30 and after 0x01, MID_TICKS after the second 0x30, and SHORT_TICKS after every other command.
- R8: done_o rises exactly (SHORT_TICKS+2)*DIV cycles after the falling edge of the final write (0x0C).
- R9: Once done_o is high it stays high, en_o stays low, and further start pulses have no effect.
- R10: Reset asserted in the middle of the sequence drives en_o and done_o low at once. The block then idles until a new start, and the new start replays the full sequence from the first 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that begins the power-up sequence |
| rs_o | output | 1 | Register select to the display (always command) |
| rw_o | output | 1 | Read/write select to the display (always write) |
| en_o | output | 1 | Display enable strobe |
| data_o | output | 8 | Display data bus |
| done_o | output | 1 | Sequence complete, sticky until reset |

## Verification
The bench measures every gap between enable pulses in clock cycles and compares it with the exact value for the command just written. A design that picked the wrong pause class, or that failed to clear the wait counter between pauses, would give one gap that is short or long by a whole count period. The power-up window is checked on both sides, which catches a wrong settling-loop count or a start taken before the first strobe. The bench watches the bus for DIV cycles after each enable fall, so a design that loaded the next byte too early fails the hold check. A reset in the middle of the sequence, followed by a fresh start, shows whether stale command-index or loop state survives reset.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PWR, ST_SETUP, ST_PULSE, ST_HOLD, ST_WAIT, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {GAP_SHORT, GAP_MID, GAP_LONG} gap_e;

  localparam int unsigned N_CMDS = 8;
  localparam int unsigned IDX_W  = $clog2(N_CMDS);

  function automatic logic [7:0] cmd_byte(input logic [IDX_W-1:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0, 3'd1, 3'd2: b = 8'h30;
      3'd3:             b = 8'h38;
      3'd4:             b = 8'h08;
      3'd5:             b = 8'h01;
      3'd6:             b = 8'h06;
      default:          b = 8'h0C;
    endcase
    return b;
  endfunction

  // pause class after each write
  function automatic gap_e cmd_gap(input logic [IDX_W-1:0] idx);
    gap_e g;
    case (idx)
      3'd0, 3'd5: g = GAP_LONG;
      3'd1:       g = GAP_MID;
      default:    g = GAP_SHORT;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen #(
  parameter int unsigned PRESCALE_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [PRESCALE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  assign tick_o = &pre_q;
endmodule

// File: rtl/lcd_delay_cnt.sv
module lcd_delay_cnt #(
  parameter int unsigned DELAY_W = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               run_i,
  output logic [DELAY_W-1:0] cnt_o,
  output logic               full_o
);
  logic [DELAY_W-1:0] cnt_q;

  // held at zero outside pauses; wraps from all ones for chained long waits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = &cnt_q;
endmodule

// File: rtl/lcd_init_fsm.sv
module lcd_init_fsm
  import lcd_init_pkg::*;
#(
  parameter int unsigned DELAY_W     = 13,
  parameter int unsigned SHORT_TICKS = 61,
  parameter int unsigned MID_TICKS   = 150,
  parameter int unsigned PWR_LOOPS   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_i,
  input  logic [DELAY_W-1:0] cnt_i,
  input  logic               full_i,
  output logic               run_o,
  output logic               en_o,
  output logic [7:0]         data_o,
  output logic               done_o
);
  localparam int unsigned LOOP_W = (PWR_LOOPS > 1) ? $clog2(PWR_LOOPS) : 1;
  localparam logic [LOOP_W-1:0] LOOP_LAST = LOOP_W'(PWR_LOOPS - 1);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(N_CMDS - 1);

  seq_state_e         state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [LOOP_W-1:0]  loop_q;
  logic [7:0]         data_q;
  logic               pend_q;
  logic [DELAY_W-1:0] tgt;

  always_comb begin
    case (cmd_gap(idx_q))
      GAP_LONG: tgt = '1;
      GAP_MID:  tgt = DELAY_W'(MID_TICKS);
      default:  tgt = DELAY_W'(SHORT_TICKS);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      loop_q  <= '0;
      data_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      // start is only remembered while idle
      if (state_q == ST_IDLE) pend_q <= pend_q | start_i;
      else                    pend_q <= 1'b0;
      if (tick_i) begin
        case (state_q)
          ST_IDLE: if (pend_q) begin
            state_q <= ST_PWR;
            loop_q  <= '0;
          end
          ST_PWR: if (full_i) begin
            if (loop_q == LOOP_LAST) begin
              state_q <= ST_SETUP;
              idx_q   <= '0;
              data_q  <= cmd_byte('0);
            end else begin
              loop_q <= loop_q + 1'b1;
            end
          end
          ST_SETUP: state_q <= ST_PULSE;
          ST_PULSE: state_q <= ST_HOLD;
          ST_HOLD:  state_q <= ST_WAIT;
          ST_WAIT: if (cnt_i == tgt) begin
            if (idx_q == IDX_LAST) begin
              state_q <= ST_DONE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              data_q  <= cmd_byte(idx_q + 1'b1);
              state_q <= ST_SETUP;
            end
          end
          ST_DONE: state_q <= ST_DONE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign run_o  = (state_q == ST_PWR) || (state_q == ST_WAIT);
  assign en_o   = (state_q == ST_PULSE);
  assign data_o = data_q;
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq #(
  parameter int unsigned PRESCALE_W  = 5,
  parameter int unsigned DELAY_W     = 13,
  parameter int unsigned SHORT_TICKS = 61,
  parameter int unsigned MID_TICKS   = 150,
  parameter int unsigned PWR_LOOPS   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       rs_o,
  output logic       rw_o,
  output logic       en_o,
  output logic [7:0] data_o,
  output logic       done_o
);
  logic               tick;
  logic               run;
  logic               full;
  logic [DELAY_W-1:0] cnt;

  lcd_tick_gen #(.PRESCALE_W(PRESCALE_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  lcd_delay_cnt #(.DELAY_W(DELAY_W)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .run_i (run),
    .cnt_o (cnt),
    .full_o(full)
  );

  lcd_init_fsm #(
    .DELAY_W    (DELAY_W),
    .SHORT_TICKS(SHORT_TICKS),
    .MID_TICKS  (MID_TICKS),
    .PWR_LOOPS  (PWR_LOOPS)
  ) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .start_i(start_i),
    .cnt_i  (cnt),
    .full_i (full),
    .run_o  (run),
    .en_o   (en_o),
    .data_o (data_o),
    .done_o (done_o)
  );

  // command writes only
  assign rs_o = 1'b0;
  assign rw_o = 1'b0;
endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk #(
  parameter int unsigned PRESCALE_W = 5
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_o,
  input logic [7:0] data_o,
  input logic       done_o
);
  localparam int unsigned DIV = 1 << PRESCALE_W;

  logic [PRESCALE_W+1:0] hi_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hi_len <= '0;
    else if (en_o) hi_len <= hi_len + 1'b1;
    else           hi_len <= '0;
  end

  assert_pulse_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_o) |-> hi_len == (PRESCALE_W+2)'(DIV));

  assert_data_during_e_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> $stable(data_o));

  assert_data_at_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_o) |-> $stable(data_o));

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  assert_quiet_after_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !en_o);
endmodule

bind lcd_init_seq lcd_init_seq_chk #(.PRESCALE_W(PRESCALE_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_o  (en_o),
  .data_o(data_o),
  .done_o(done_o)
);

// File: tb/lcd_init_seq_test.sv
module lcd_init_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW   = 2;
  localparam int DW   = 5;
  localparam int SHT  = 3;
  localparam int MID  = 7;
  localparam int LOOPS = 2;
  localparam int DIV  = 1 << PW;
  localparam int LONG = (1 << DW) - 1;
  localparam int WATCHDOG = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       rs, rw, en, done;
  logic [7:0] data;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int n_rise = 0, wr_idx = 0;
  int last_fall = 0, hi_start = 0, start_cyc = 0;
  int hold_left = 0;
  logic [7:0] held = 8'h00;
  logic prev_en = 1'b0, prev_done = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_init_seq #(
    .PRESCALE_W(PW), .DELAY_W(DW), .SHORT_TICKS(SHT),
    .MID_TICKS(MID), .PWR_LOOPS(LOOPS)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rs_o(rs), .rw_o(rw), .en_o(en), .data_o(data), .done_o(done)
  );

  function automatic logic [7:0] exp_byte(int i);
    case (i)
      0, 1, 2: return 8'h30;
      3: return 8'h38;
      4: return 8'h08;
      5: return 8'h01;
      6: return 8'h06;
      default: return 8'h0C;
    endcase
  endfunction

  function automatic int gap_ticks(int i);
    if (i == 0 || i == 5) return LONG;
    if (i == 1) return MID;
    return SHT;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // bus monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      wr_idx = 0; prev_en = 1'b0; prev_done = 1'b0; hold_left = 0;
    end else begin
      if (start && wr_idx == 0 && !done) start_cyc = cyc;
      if (en && !prev_en) begin
        n_rise++;
        hi_start = cyc;
        held = data;
        check(!rs && !rw, "R4", {rs, rw}, 0);
        check(!done, "R9", done, 0);
        if (wr_idx == 0) begin
          check(cyc - start_cyc >= (LOOPS*(LONG+1)+1)*DIV+1 &&
                cyc - start_cyc <= (LOOPS*(LONG+1)+2)*DIV,
                "R2", cyc - start_cyc, (LOOPS*(LONG+1)+1)*DIV+1);
        end else begin
          check(cyc - last_fall == (gap_ticks(wr_idx-1)+3)*DIV, "R7",
                cyc - last_fall, (gap_ticks(wr_idx-1)+3)*DIV);
        end
      end
      if (en && prev_en && data != held)
        check(1'b0, "R6", data, held);
      if (!en && prev_en) begin
        check(cyc - hi_start == DIV, "R5", cyc - hi_start, DIV);
        check(data == exp_byte(wr_idx), "R3", data, exp_byte(wr_idx));
        check(wr_idx < 8, "R3", wr_idx, 7);
        wr_idx++;
        last_fall = cyc;
        hold_left = DIV;
      end else if (hold_left > 0) begin
        hold_left--;
        if (hold_left == 0) check(data == held, "R6", data, held);
        else if (data != held) begin
          check(1'b0, "R6", data, held);
          hold_left = 0;
        end
      end
      if (done && !prev_done) begin
        check(wr_idx == 8, "R8", wr_idx, 8);
        check(cyc - last_fall == (SHT+2)*DIV, "R8", cyc - last_fall, (SHT+2)*DIV);
      end
      if (prev_done) check(done, "R9", done, 1);
      prev_en = en;
      prev_done = done;
    end
    if (cyc > WATCHDOG && !finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  initial begin
    int rises;
    repeat (5) @(negedge clk);
    check(!en && !rs && !rw && !done, "R1", {en, rs, rw, done}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (100) @(negedge clk);
    check(n_rise == 0, "R1", n_rise, 0);
    check(!en && !done, "R1", {en, done}, 0);

    pulse_start();
    while (!done) @(negedge clk);
    check(wr_idx == 8, "R3", wr_idx, 8);

    rises = n_rise;
    pulse_start();
    repeat (300) @(negedge clk);
    check(n_rise == rises, "R9", n_rise, rises);
    check(done && !en, "R9", {done, en}, 2);

    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    pulse_start();
    while (wr_idx < 4) @(negedge clk);
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b0;
    #1 check(!en && !done, "R10", {en, done}, 0);
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b1;
    rises = n_rise;
    repeat (200) @(negedge clk);
    check(n_rise == rises && !done, "R10", n_rise, rises);
    pulse_start();
    while (!done) @(negedge clk);
    check(wr_idx == 8, "R10", wr_idx, 8);
    check(n_rise == rises + 8, "R10", n_rise, rises + 8);

    finished = 1'b1;
    summary();
  end
endmodule